// File: doc/BRIEF.md
# Frequency Watchdog With Safe Fallback

This block supervises the frequency selection of a programmable clock generator. It picks the active frequency code from either the latched hardware select pins or a code written by software. After the watchdog is armed, it counts a programmed number of time units. Each unit is a fixed number of prescaler ticks. If software does not disarm the watchdog before the count runs out, the block raises a sticky alarm, replaces the active code with a stored safe code, and drives an active-low system reset pulse.

The reset pulse is also issued whenever the effective frequency code changes, so downstream logic restarts on a settled clock. Software clears the alarm by writing the control register. That write also reloads the countdown. The PLL and the register file are outside this block: enable, count, safe code, source select and the write strobe arrive as plain inputs.

Top module: `freq_watchdog`

## Requirements
- R1: With no alarm, `freq_code_o` equals `sw_code_i` when `sw_sel_i` is 1 and `hw_fs_i` when `sw_sel_i` is 0. The 5-bit code is {extra select bit, FS3..FS0}.
- R2: When enabled and armed with count N ≥ 1, `alarm_o` rises after exactly N × `UNIT_TICKS` ticks, counted from the last reload.
- R3: A count of 0 raises the alarm on the first unit boundary, which is `UNIT_TICKS` ticks after the reload.
- R4: The countdown and the unit prescaler restart on any of three events: a rising edge of `wd_en_i`, a pulse on `cfg_wr_i`, or a change of the effective code.
- R5: While `wd_en_i` is 0, no alarm is raised, whatever number of ticks arrives.
- R6: While `alarm_o` is 1, `freq_code_o` equals `safe_code_i`. Changes on the select inputs do not reach the output and start no reset pulse.
- R7: `alarm_o` stays 1 until a `cfg_wr_i` pulse clears it in the following cycle. Clearing `wd_en_i` does not clear it.
- R8: `sys_rst_no` goes low in the cycle after a timeout or after a change of the effective code. It stays low until `RST_TICKS` ticks have passed.
- R9: After reset, `alarm_o` is 0 and `sys_rst_no` is 1. The first code seen after reset starts no reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaler tick, one cycle wide |
| wd_en_i | input | 1 | Watchdog enable |
| cfg_wr_i | input | 1 | Control/count register write strobe |
| wd_count_i | input | CNT_W | Timeout in units |
| safe_code_i | input | 5 | Fallback frequency code |
| sw_sel_i | input | 1 | 1 selects the software code |
| sw_code_i | input | 5 | Software frequency code |
| hw_fs_i | input | 5 | Latched hardware select pins |
| freq_code_o | output | 5 | Effective frequency code |
| alarm_o | output | 1 | Watchdog alarm status |
| sys_rst_no | output | 1 | Active-low system reset pulse |

## Verification
Several rules are checked by assertions on every cycle. The alarm must hold until a write. A write must clear the alarm. An alarm may only rise while the watchdog is enabled. Every code change and every alarm must pull the reset low. The reset pulse may end only on a tick. The exact timeout lengths cannot be checked that way, and the bench scenarios cover them: N units, the zero count, and a restart caused by a rewrite. The bench scenarios also show that a disarm in time prevents the alarm, that select changes have no effect during an alarm, and which code and status go with each reset pulse.

// File: rtl/freq_wd_pkg.sv
package freq_wd_pkg;
  localparam int unsigned FS_W = 5;
  typedef logic [FS_W-1:0] fs_code_t;
endpackage

// File: rtl/wd_code_sel.sv
module wd_code_sel
  import freq_wd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     alarm_i,
  input  logic     sw_sel_i,
  input  fs_code_t sw_code_i,
  input  fs_code_t hw_fs_i,
  input  fs_code_t safe_code_i,
  output fs_code_t code_o,
  output logic     chg_o
);
  fs_code_t req_code;
  fs_code_t prev_q;
  logic     vld_q;

  always_comb begin
    req_code = sw_sel_i ? sw_code_i : hw_fs_i;
    code_o   = alarm_i ? safe_code_i : req_code;
  end

  assign chg_o = vld_q && (code_o != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= code_o;
      vld_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/wd_timer.sv
module wd_timer #(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned UNIT_TICKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             cfg_wr_i,
  input  logic             chg_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             alarm_o,
  output logic             timeout_o
);
  logic             en_q;
  logic             reload;
  logic             unit;
  logic             run;
  logic [CNT_W-1:0] cnt_q;
  logic             alarm_q;

  assign reload = (en_i && !en_q) || cfg_wr_i || chg_i;
  assign run    = en_i && !alarm_q && !reload;

  generate
    if (UNIT_TICKS <= 1) begin : g_no_pre
      assign unit = run && tick_i;
    end else begin : g_pre
      localparam int unsigned PRE_W = $clog2(UNIT_TICKS);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_TICKS - 1);
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       pre_q <= '0;
        else if (!run)                     pre_q <= '0;
        else if (tick_i)                   pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
      end
      assign unit = run && tick_i && (pre_q == PRE_LAST);
    end
  endgenerate

  // count N expires on the Nth unit; 0 behaves like 1
  assign timeout_o = unit && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      cnt_q   <= '0;
      alarm_q <= 1'b0;
    end else begin
      en_q <= en_i;
      if (reload)                   cnt_q <= count_i;
      else if (unit && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (cfg_wr_i)       alarm_q <= 1'b0;
      else if (timeout_o) alarm_q <= 1'b1;
    end
  end

  assign alarm_o = alarm_q;
endmodule

// File: rtl/wd_rst_pulse.sv
module wd_rst_pulse #(
  parameter int unsigned RST_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic trig_i,
  output logic rst_no
);
  localparam int unsigned RW = $clog2(RST_TICKS + 1);
  logic [RW-1:0] rcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      rcnt_q <= '0;
    else if (trig_i)                  rcnt_q <= RW'(RST_TICKS);
    else if (tick_i && rcnt_q != '0)  rcnt_q <= rcnt_q - 1'b1;
  end

  assign rst_no = (rcnt_q == '0);
endmodule

// File: rtl/freq_watchdog.sv
module freq_watchdog
  import freq_wd_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned UNIT_TICKS = 4,
  parameter int unsigned RST_TICKS  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wd_en_i,
  input  logic             cfg_wr_i,
  input  logic [CNT_W-1:0] wd_count_i,
  input  logic [4:0]       safe_code_i,
  input  logic             sw_sel_i,
  input  logic [4:0]       sw_code_i,
  input  logic [4:0]       hw_fs_i,
  output logic [4:0]       freq_code_o,
  output logic             alarm_o,
  output logic             sys_rst_no
);
  logic     alarm;
  logic     timeout;
  logic     chg;
  fs_code_t code;

  wd_code_sel u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alarm_i     (alarm),
    .sw_sel_i    (sw_sel_i),
    .sw_code_i   (sw_code_i),
    .hw_fs_i     (hw_fs_i),
    .safe_code_i (safe_code_i),
    .code_o      (code),
    .chg_o       (chg)
  );

  wd_timer #(.CNT_W(CNT_W), .UNIT_TICKS(UNIT_TICKS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .en_i      (wd_en_i),
    .cfg_wr_i  (cfg_wr_i),
    .chg_i     (chg),
    .count_i   (wd_count_i),
    .alarm_o   (alarm),
    .timeout_o (timeout)
  );

  wd_rst_pulse #(.RST_TICKS(RST_TICKS)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .trig_i (timeout || chg),
    .rst_no (sys_rst_no)
  );

  assign freq_code_o = code;
  assign alarm_o     = alarm;
endmodule

// File: rtl/freq_watchdog_chk.sv
module freq_watchdog_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wd_en_i,
  input logic       cfg_wr_i,
  input logic [4:0] freq_code_o,
  input logic       alarm_o,
  input logic       sys_rst_no
);
  logic       seen_q;
  logic [4:0] last_code_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q      <= 1'b0;
      last_code_q <= '0;
    end else begin
      seen_q      <= 1'b1;
      last_code_q <= freq_code_o;
    end
  end

  p_alarm_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o && !cfg_wr_i |=> alarm_o);

  p_alarm_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> !alarm_o);

  p_alarm_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_en_i && !alarm_o |=> !alarm_o);

  p_alarm_resets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> !sys_rst_no);

  p_change_resets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && (freq_code_o != last_code_q) |=> !sys_rst_no);

  p_pulse_ends_on_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_no && !tick_i |=> !sys_rst_no);
endmodule

bind freq_watchdog freq_watchdog_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .wd_en_i     (wd_en_i),
  .cfg_wr_i    (cfg_wr_i),
  .freq_code_o (freq_code_o),
  .alarm_o     (alarm_o),
  .sys_rst_no  (sys_rst_no)
);

// File: tb/freq_watchdog_tb.sv
module freq_watchdog_tb;
  localparam int UNIT = 4;
  localparam int RSTT = 2;
  localparam logic [4:0] SAFE = 5'h11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, en = 1'b0, cfg_wr = 1'b0, sw_sel = 1'b0;
  logic [7:0] count = 8'd3;
  logic [4:0] sw_code = 5'h0A, hw_fs = 5'h03;
  logic [4:0] code;
  logic       alarm, srst_n;

  int total = 0, bad = 0;
  logic [5:0] exp_q[$];
  logic       prev_srst = 1'b1;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  freq_watchdog #(.CNT_W(8), .UNIT_TICKS(UNIT), .RST_TICKS(RSTT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wd_en_i(en), .cfg_wr_i(cfg_wr),
    .wd_count_i(count), .safe_code_i(SAFE), .sw_sel_i(sw_sel), .sw_code_i(sw_code),
    .hw_fs_i(hw_fs), .freq_code_o(code), .alarm_o(alarm), .sys_rst_no(srst_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic cfg_write();
    @(negedge clk) cfg_wr = 1'b1;
    @(negedge clk) cfg_wr = 1'b0;
  endtask

  task automatic expect_pulse(input logic [4:0] c, input logic a);
    exp_q.push_back({a, c});
  endtask

  // monitor: every falling edge of the reset output is matched to an expected item
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_srst && !srst_n) begin
        if (exp_q.size() == 0) check("R8 unexpected pulse", {3'b0, code}, 8'hFF);
        else begin
          logic [5:0] e;
          e = exp_q.pop_front();
          check("R8 pulse code", {3'b0, code}, {3'b0, e[4:0]});
          check("R6 pulse alarm", {7'b0, alarm}, {7'b0, e[5]});
        end
      end
      prev_srst = srst_n;
    end
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 alarm", {7'b0, alarm}, 8'd0);
    check("R9 reset out", {7'b0, srst_n}, 8'd1);
    check("R1 hw code", {3'b0, code}, 8'h03);
    repeat (3) @(negedge clk);
    check("R9 no pulse", {7'b0, srst_n}, 8'd1);

    // R1 software select, R8 pulse on change
    expect_pulse(5'h0A, 1'b0);
    sw_sel = 1'b1;
    @(negedge clk);
    check("R1 sw code", {3'b0, code}, 8'h0A);
    check("R8 low", {7'b0, srst_n}, 8'd0);
    ticks(1);
    check("R8 held", {7'b0, srst_n}, 8'd0);
    ticks(1);
    check("R8 released", {7'b0, srst_n}, 8'd1);

    // R2 timeout 3 units = 12 ticks
    count = 8'd3;
    @(negedge clk) en = 1'b1;
    ticks(11);
    check("R2 before", {7'b0, alarm}, 8'd0);
    expect_pulse(SAFE, 1'b1);
    ticks(1);
    check("R2 at timeout", {7'b0, alarm}, 8'd1);
    check("R6 safe code", {3'b0, code}, {3'b0, SAFE});
    ticks(3);
    // R6 select change ignored during alarm
    sw_code = 5'h0B;
    repeat (4) @(negedge clk);
    check("R6 code held", {3'b0, code}, {3'b0, SAFE});
    check("R6 no pulse", {7'b0, srst_n}, 8'd1);
    en = 1'b0;
    ticks(5);
    check("R7 sticky", {7'b0, alarm}, 8'd1);
    en = 1'b1;

    // R7 clear
    expect_pulse(5'h0B, 1'b0);
    cfg_write();
    check("R7 cleared", {7'b0, alarm}, 8'd0);
    ticks(3);

    // R5 disarm in time
    count = 8'd2;
    cfg_write();
    ticks(7);
    en = 1'b0;
    ticks(20);
    check("R5 no alarm", {7'b0, alarm}, 8'd0);

    // R4 rearm, then rewrite restarts countdown
    @(negedge clk) en = 1'b1;
    ticks(7);
    cfg_write();
    ticks(7);
    check("R4 restarted", {7'b0, alarm}, 8'd0);
    expect_pulse(SAFE, 1'b1);
    ticks(1);
    check("R4 expiry", {7'b0, alarm}, 8'd1);
    ticks(3);

    // R3 count zero: clear reloads, alarm at first unit
    count = 8'd0;
    expect_pulse(5'h0B, 1'b0);
    cfg_write();
    ticks(3);
    check("R3 before", {7'b0, alarm}, 8'd0);
    expect_pulse(SAFE, 1'b1);
    ticks(1);
    check("R3 at unit", {7'b0, alarm}, 8'd1);
    ticks(3);

    // R1/R6 hardware path, ignored until clear
    en = 1'b0; sw_sel = 1'b0; hw_fs = 5'h07;
    repeat (3) @(negedge clk);
    check("R6 hw ignored", {3'b0, code}, {3'b0, SAFE});
    expect_pulse(5'h07, 1'b0);
    cfg_write();
    check("R1 hw after clear", {3'b0, code}, 8'h07);
    ticks(3);
    check("R8 done", {7'b0, srst_n}, 8'd1);

    done = 1'b1;
    check("R8 all pulses seen", 8'(exp_q.size()), 8'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule